// File: doc/BRIEF.md
# Serial Pad Configuration Chain Loader

This block holds a software-visible copy of the configuration word for every I/O pad and, on request, streams all of those words down a single daisy chain that passes through small per-pad holding cells. Software writes the configuration words through a simple register bus, then sets a transfer bit. The block captures the whole bank, clocks it out one bit at a time on a divided serial clock and finishes with one load strobe. On that strobe every cell moves its shifted word into its live configuration. No parallel wiring has to run from the register bank to each pad.

The sequencer is a four-state machine:
- `ST_IDLE` waits for a transfer request. On a request it goes to `ST_LOW` and captures the mirror.
- `ST_LOW` presents a data bit with the serial clock low and always goes to `ST_HIGH`.
- `ST_HIGH` raises the serial clock. From there it returns to `ST_LOW`, unless the last bit has gone out, in which case it goes to `ST_LOAD`.
- `ST_LOAD` drives the one-cycle load strobe and returns to `ST_IDLE`.

The block reads as busy in every state other than `ST_IDLE`.

Top module: `pad_cfg_loader`

## Requirements
- R1: After reset, the configuration words of pads 0 and 1 read back 0x1801 and those of pads 2 to 31 read back 0x0403. The word of pad i is at byte offset 0x08 + 4*i, in bits 12:0, and bits 31:13 read zero. The transfer register at offset 0x04 reads 0, and `busy`, `ser_clk` and `ser_load` are low.
- R2: A write to offset 0x08 + 4*i stores bits 12:0 of the write data as the word of pad i. Bits 31:13 of the write data are discarded, and no other pad's word changes.
- R3: Writing a value with bit 0 set to offset 0x04 while idle starts a transfer. From the next cycle, bit 0 of a read at 0x04 returns 1 and `busy` is high until the transfer ends. After that, bit 0 reads 0.
- R4: A transfer sends exactly 416 bits. The word of pad 31 goes first and the word of pad 0 goes last, each most significant bit first. After the load strobe, a chain of 32 cells, each taking one bit on every rising `ser_clk` edge, holds the word of pad i in cell i.
- R5: While shifting, `ser_clk` runs at half the system clock: one cycle low, then one cycle high. It is low while idle and during the load strobe.
- R6: `ser_dat` changes only on the cycle in which `ser_clk` goes low. It holds its value for the whole high phase.
- R7: After the 416th high phase, `ser_load` is high for exactly one cycle, and `busy` is low on the cycle after that.
- R8: A configuration write made during a transfer is stored at once and reads back. The transfer in progress still sends the words captured at its start, and the new word is sent by the next transfer.
- R9: A write to offset 0x04 during a transfer neither restarts nor lengthens it. A write to 0x04 with bit 0 clear starts nothing.
- R10: Reads at offsets 0x00 and 0x88 return 0, and writes to them change no configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the control region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not reading) |
| busy | output | 1 | Transfer in progress |
| ser_clk | output | 1 | Serial chain clock (system clock / 2 while shifting) |
| ser_dat | output | 1 | Serial chain data |
| ser_load | output | 1 | One-cycle strobe that commits every cell |

## Verification
The bench builds a chain of 32 cell models and compares every cell with the words that were programmed. A design that reversed the pad order or the bit order, or that stopped one bit short or long, would leave every cell wrong or shifted by one bit. The bench rewrites a pad word and re-requests a transfer while a transfer is running. A design that shifted straight from the live mirror would put the new word into the running stream, and one that honoured the second request would send more than 416 clocks. The bench also watches `ser_dat` across each high phase and the shape of the clock. This catches data that changes on the rising edge, a clock that stalls, and a load strobe that lasts longer than one cycle or that leaves `busy` asserted.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOAD = 2'd3
    } seq_state_e;
endpackage

// File: rtl/pcl_mirror.sv
module pcl_mirror #(
    parameter int NUM_PADS    = 32,
    parameter int CFG_W       = 13,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_SPECIAL = 2,
    parameter logic [CFG_W-1:0] DEF_SPECIAL = 13'h1801,
    parameter logic [CFG_W-1:0] DEF_NORMAL  = 13'h0403,
    parameter int CFG_BASE    = 8,
    parameter int XFER_OFF    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      busy,
    output logic [DATA_W-1:0]         rdata,
    output logic                      start,
    output logic [NUM_PADS*CFG_W-1:0] cfg_flat
);
    localparam int PAD_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
    localparam logic [ADDR_W:0]   BASE_A = (ADDR_W+1)'(CFG_BASE);
    localparam logic [ADDR_W:0]   END_A  = (ADDR_W+1)'(CFG_BASE + 4*NUM_PADS);
    localparam logic [ADDR_W-1:0] XFER_A = ADDR_W'(XFER_OFF);

    logic              hit_cfg;
    logic              hit_xfer;
    logic [ADDR_W-1:0] rel;
    logic [PAD_W-1:0]  pad_sel;
    logic [CFG_W-1:0]  cfg_arr [NUM_PADS];
    logic              unused_bits;

    assign hit_cfg  = ({1'b0, addr} >= BASE_A) && ({1'b0, addr} < END_A) && (addr[1:0] == 2'b00);
    assign hit_xfer = (addr == XFER_A);
    assign rel      = addr - ADDR_W'(CFG_BASE);
    assign pad_sel  = rel[PAD_W+1:2];
    assign unused_bits = ^{wdata[DATA_W-1:CFG_W], rel};

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        localparam logic [CFG_W-1:0] DEF_P = (p < NUM_SPECIAL) ? DEF_SPECIAL : DEF_NORMAL;
        logic wr_hit;
        assign wr_hit = sel && wr && hit_cfg && (pad_sel == PAD_W'(p));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_arr[p] <= DEF_P;
            else if (wr_hit)
                cfg_arr[p] <= wdata[CFG_W-1:0];
        end
        assign cfg_flat[p*CFG_W +: CFG_W] = cfg_arr[p];
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (hit_cfg)
                rdata[CFG_W-1:0] = cfg_arr[pad_sel];
            else if (hit_xfer)
                rdata[0] = busy;
        end
    end

    assign start = sel && wr && hit_xfer && wdata[0] && !busy;

    AST_MIRROR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |=> $stable(cfg_flat)); // R2
endmodule

// File: rtl/pcl_shift.sv
module pcl_shift #(
    parameter int TOTAL = 416
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             advance,
    input  logic [TOTAL-1:0] par_in,
    output logic             msb
);
    logic [TOTAL-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sreg <= '0;
        else if (capture)
            sreg <= par_in;
        else if (advance)
            sreg <= {sreg[TOTAL-2:0], 1'b0};
    end

    assign msb = sreg[TOTAL-1];
endmodule

// File: rtl/pcl_seq.sv
module pcl_seq
    import pcl_pkg::*;
#(
    parameter int TOTAL = 416
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic capture,
    output logic advance,
    output logic ser_clk,
    output logic ser_load,
    output logic busy
);
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] sent;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sent  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE)
                sent <= '0;
            else if (state == ST_HIGH)
                sent <= sent + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_LOW;
            ST_LOW:  nxt = ST_HIGH;
            ST_HIGH: nxt = (sent == LAST) ? ST_LOAD : ST_LOW;
            ST_LOAD: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        capture  = 1'b0;
        advance  = 1'b0;
        ser_clk  = 1'b0;
        ser_load = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                capture = start;
            end
            ST_LOW:  ;
            ST_HIGH: begin
                ser_clk = 1'b1;
                advance = 1'b1;
            end
            ST_LOAD: ser_load = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    logic [CNT_W-1:0] chk_rises;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chk_rises <= '0;
        else if (capture)
            chk_rises <= '0;
        else if (ser_clk)
            chk_rises <= chk_rises + 1'b1;
    end

    AST_CLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |=> !ser_clk); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (busy && !ser_clk && !ser_load)); // R3
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |=> (!ser_load && !busy)); // R7
    AST_FULL_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> (chk_rises == CNT_W'(TOTAL))); // R4
endmodule

// File: rtl/pad_cfg_loader.sv
module pad_cfg_loader #(
    parameter int NUM_PADS    = 32,
    parameter int CFG_W       = 13,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_SPECIAL = 2,
    parameter logic [CFG_W-1:0] DEF_SPECIAL = 13'h1801,
    parameter logic [CFG_W-1:0] DEF_NORMAL  = 13'h0403,
    parameter int CFG_BASE    = 8,
    parameter int XFER_OFF    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              ser_load
);
    localparam int TOTAL = NUM_PADS * CFG_W;

    logic             start;
    logic             capture;
    logic             advance;
    logic [TOTAL-1:0] cfg_flat;
    logic [TOTAL-1:0] stream_order;

    pcl_mirror #(
        .NUM_PADS(NUM_PADS), .CFG_W(CFG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .NUM_SPECIAL(NUM_SPECIAL), .DEF_SPECIAL(DEF_SPECIAL), .DEF_NORMAL(DEF_NORMAL),
        .CFG_BASE(CFG_BASE), .XFER_OFF(XFER_OFF)
    ) u_mirror (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .busy(busy), .rdata(bus_rdata), .start(start),
        .cfg_flat(cfg_flat)
    );

    // Farthest pad occupies the top of the stream so it leaves first.
    assign stream_order = cfg_flat;

    pcl_seq #(.TOTAL(TOTAL)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .capture(capture),
        .advance(advance), .ser_clk(ser_clk), .ser_load(ser_load), .busy(busy)
    );

    pcl_shift #(.TOTAL(TOTAL)) u_shift (
        .clk(clk), .rst_n(rst_n), .capture(capture), .advance(advance),
        .par_in(stream_order), .msb(ser_dat)
    );

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_dat)); // R6
endmodule

// File: tb/sim_pad_cfg_loader.sv
module sim_pad_cfg_loader;
    localparam int NP = 32;
    localparam int CW = 13;
    localparam int TOT = NP * CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        busy, ser_clk, ser_dat, ser_load;

    always #2.5 clk = ~clk;

    pad_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [CW-1:0] exp_cfg [NP];
    logic [CW-1:0] exp_q [$];

    // behavioural cell chain: cell 0 is nearest the block
    logic [CW-1:0] chain [NP];
    int edge_cnt = 0;
    always @(posedge ser_clk) begin
        for (int p = NP - 1; p > 0; p--)
            chain[p] <= {chain[p][CW-2:0], chain[p-1][CW-1]};
        chain[0] <= {chain[0][CW-2:0], ser_dat};
        edge_cnt <= edge_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cfg_write(input int p, input logic [31:0] d);
        bus_write(8'(8 + 4*p), d);
        exp_cfg[p] = d[CW-1:0];
    endtask

    task automatic check_mirror(input string req);
        logic [31:0] d;
        for (int p = 0; p < NP; p++) begin
            bus_read(8'(8 + 4*p), d);
            check(req, d, {19'b0, exp_cfg[p]});
        end
    endtask

    // driver: push expected cell contents, then request a transfer
    task automatic start_transfer();
        logic [31:0] d;
        for (int p = 0; p < NP; p++) exp_q.push_back(exp_cfg[p]);
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, d);
        check("R3 busy readback", {31'b0, d[0]}, 32'h1);
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 2000; i++) begin
            bus_read(8'h04, d);
            if (d[0] == 1'b0) break;
        end
        check("R3 done readback", d, 32'h0);
    endtask

    // monitor: stream shape and scoreboard compare at the load strobe
    int  base_edges = 0;
    bit  shape_err = 0;
    logic prev_clk = 0, prev_dat = 0, prev_busy = 0, prev_load = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (busy && !prev_busy) begin
                    base_edges = edge_cnt;
                    shape_err = 0;
                end
                if (ser_clk && (ser_dat !== prev_dat)) begin
                    shape_err = 1;
                    $display("FAIL R6 data moved in high phase actual=%b expected=%b", ser_dat, prev_dat);
                end
                if (busy && prev_busy && !ser_load && (ser_clk === prev_clk)) begin
                    shape_err = 1;
                    $display("FAIL R5 clock did not toggle actual=%b expected=%b", ser_clk, !prev_clk);
                end
                if (!busy && ser_clk) begin
                    shape_err = 1;
                    $display("FAIL R5 clock high while idle actual=1 expected=0");
                end
                if (prev_load)
                    check("R7 strobe one cycle then idle", {30'b0, ser_load, busy}, 32'h0);
                if (ser_load) begin
                    checks++;
                    if (shape_err) fails++;
                    check("R4 R9 bit count", edge_cnt - base_edges, TOT);
                    for (int p = 0; p < NP; p++) begin
                        if (exp_q.size() == 0) begin
                            check("R4 scoreboard empty", 32'h0, 32'h1);
                        end else begin
                            logic [CW-1:0] e;
                            e = exp_q.pop_front();
                            check($sformatf("R4 cell %0d", p), {19'b0, chain[p]}, {19'b0, e});
                        end
                    end
                end
                prev_clk = ser_clk; prev_dat = ser_dat;
                prev_busy = busy; prev_load = ser_load;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int p = 0; p < NP; p++) exp_cfg[p] = (p < 2) ? 13'h1801 : 13'h0403;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 idle outputs", {29'b0, busy, ser_clk, ser_load}, 32'h0);
        bus_read(8'h04, d);
        check("R1 transfer reads 0", d, 32'h0);
        check_mirror("R1 default word");

        // R10: unmapped offsets
        bus_read(8'h00, d);  check("R10 read 0x00", d, 32'h0);
        bus_read(8'h88, d);  check("R10 read 0x88", d, 32'h0);
        bus_write(8'h88, 32'h1FFF);
        bus_write(8'h00, 32'h0ABC);
        check_mirror("R10 mirror untouched");

        // R9: writing 0 to transfer starts nothing
        bus_write(8'h04, 32'h0);
        repeat (3) @(negedge clk);
        check("R9 zero write no start", {30'b0, busy, ser_clk}, 32'h0);

        // R4: defaults through the chain
        start_transfer();
        wait_idle();

        // R2: distinct pattern with upper junk bits
        for (int p = 0; p < NP; p++)
            cfg_write(p, 32'hFFFF_E000 | ((p * 32'h13B) ^ 32'h0A5A));
        check_mirror("R2 write readback");
        start_transfer();

        // R8 / R9: writes while shifting
        bus_write(8'h24, 32'h1ABC);
        bus_write(8'h04, 32'h1);
        bus_write(8'h04, 32'h0);
        bus_read(8'h24, d);
        check("R8 mirror accepts during transfer", d, 32'h1ABC);
        wait_idle();
        exp_cfg[7] = 13'h1ABC;
        start_transfer();
        wait_idle();

        // R4: alternating extremes
        for (int p = 0; p < NP; p++)
            cfg_write(p, (p % 2) ? 32'h1FFF : 32'h0);
        start_transfer();
        wait_idle();

        repeat (4) @(negedge clk);
        check("R7 scoreboard drained", exp_q.size(), 32'h0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule